// File: doc/BRIEF.md
# Nested-Loop Sequencer for a Bit-Serial Multiplier

This block drives the control inputs of an N-by-N bit-serial shift-and-add multiplier. The multiplier datapath is a separate block. Two loop counters and a three-state one-hot machine produce the control pulses. The inner counter spaces out N accumulate cycles. The outer counter counts N product bits, and each bit ends with a single step cycle. A full product therefore takes N·(N+1) cycles. The count of accumulate cycles is N², and one result bit is produced for every N accumulate cycles.

The machine has three states:
- `S_IDLE`: waiting for a start.
- `S_INNER`: the accumulate cycles.
- `S_STEP`: one outer step.

It has four transitions:
- **launch**: `S_IDLE`→`S_INNER` when `start` is sampled high.
- **inner_done**: `S_INNER`→`S_STEP` when the inner counter reaches its terminal count.
- **next_bit**: `S_STEP`→`S_INNER` while the outer counter is below its terminal count.
- **finish**: `S_STEP`→`S_IDLE` when the outer counter is at its terminal count.

Every control output is decoded from a single state bit, except `done`, which also uses the outer terminal count.

Top module: `mul_seq_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces `S_IDLE` at once and clears both loop counters. While idle, every output is 0.
- R2: While idle with `start` low, the block stays idle. A `start` sampled high in `S_IDLE` makes the first accumulate cycle appear in the very next cycle.
- R3: An accumulate cycle asserts exactly `shift_a`, `sel_sum` and `shift_hi`. Output vector {done,dp_clr,sel_sum,shift_lo,shift_hi,shift_b,shift_a} = 7'b0010101. Each burst of accumulate cycles lasts exactly N cycles.
- R4: An outer step asserts exactly `shift_b`, `shift_lo`, `shift_hi` and `dp_clr`. The vector is 7'b0101110, with bit 6 added on the last step. Each step lasts one cycle and follows every burst of N accumulate cycles.
- R5: One run yields exactly N² `shift_a` pulses and exactly N `shift_b` pulses. Counting from the start edge, cycle c is a step when c mod (N+1) = 0.
- R6: `done` is high for exactly one cycle, during the final outer step. That is cycle N·(N+1) after the start edge. The block is idle, with all outputs 0, from the next cycle on.
- R7: A `start` sampled high during `S_INNER` or `S_STEP` has no effect on the run in progress.
- R8: Each loop counter advances only when enabled. It raises its terminal flag at value N-1 and wraps to 0 from there. A synchronous clear takes priority over enable. As a result, back-to-back runs and non-power-of-two N behave identically to the first run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a product; sampled only while idle |
| shift_a | output | 1 | Shift the multiplicand-side register |
| shift_b | output | 1 | Shift the multiplier-side register |
| shift_hi | output | 1 | Shift the upper half of the product register |
| shift_lo | output | 1 | Shift the lower half of the product register |
| sel_sum | output | 1 | Select the adder sum into the upper half |
| dp_clr | output | 1 | Clear for the datapath at each outer step |
| done | output | 1 | One-cycle pulse on the final outer step |

## Verification
Every output is a plain decode of the registered state. The first accumulate cycle is therefore due one clock after the edge that samples `start`. The cycle c after that edge is a step exactly when c mod (N+1) = 0, and `done` is due at c = N·(N+1). The bench drives and samples on falling edges and numbers each falling edge from the start edge. It compares the whole output vector against the value predicted for that index, so an output that arrives one cycle early or late shows up as a mismatch. Separate instances with N = 4, 5 and 8 run the same directed scenarios. These cover plain runs, back-to-back runs, start pulses during a run, and a reset in the middle of a run.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'b001,
        S_INNER = 3'b010,
        S_STEP  = 3'b100
    } seq_state_t;

endpackage

// File: rtl/loop_ctr.sv
module loop_ctr #(
    parameter int TERM = 7,
    parameter int CW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          tc
);
    localparam logic [CW-1:0] LAST = CW'(TERM);

    assign tc = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tc ? '0 : cnt + 1'b1;
        end
    end

    a_r8_wrap_at_term: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && tc) |=> (cnt == '0));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));

    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import mul_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tc_inner,
    input  logic       tc_outer,
    output seq_state_t state
);
    seq_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start)    nxt = S_INNER;
            S_INNER: if (tc_inner) nxt = S_STEP;
            S_STEP:  nxt = tc_outer ? S_IDLE : S_INNER;
            default: nxt = S_IDLE;
        endcase
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state));

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (state == S_INNER));

    a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> (state == S_IDLE));

    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP) |=> (state != S_STEP));

    a_r3_inner_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_INNER && !tc_inner) |=> (state == S_INNER));

endmodule

// File: rtl/mul_seq_ctrl.sv
module mul_seq_ctrl
    import mul_seq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic shift_a,
    output logic shift_b,
    output logic shift_hi,
    output logic shift_lo,
    output logic sel_sum,
    output logic dp_clr,
    output logic done
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    seq_state_t    state;
    logic          q_idle, q_inner, q_step;
    logic          tc_i, tc_j;
    logic [CW-1:0] cnt_i, cnt_j;

    assign q_idle  = state[0];
    assign q_inner = state[1];
    assign q_step  = state[2];

    seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tc_inner (tc_j),
        .tc_outer (tc_i),
        .state    (state)
    );

    // Inner loop: one count per accumulate cycle, cleared at each outer step.
    loop_ctr #(.TERM(N-1), .CW(CW)) u_ctr_j (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q_step),
        .en    (q_inner),
        .cnt   (cnt_j),
        .tc    (tc_j)
    );

    // Outer loop: one count per outer step, cleared while idle.
    loop_ctr #(.TERM(N-1), .CW(CW)) u_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q_idle),
        .en    (q_step),
        .cnt   (cnt_i),
        .tc    (tc_i)
    );

    assign shift_a  = q_inner;
    assign sel_sum  = q_inner;
    assign shift_b  = q_step;
    assign shift_lo = q_step;
    assign dp_clr   = q_step;
    assign shift_hi = q_inner | q_step;
    assign done     = q_step & tc_i;

    a_r6_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == S_IDLE && !shift_hi));

    a_r7_busy_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q_inner && !tc_j && start) |=> q_inner);

    a_r3_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_a && shift_b));

    a_r5_outer_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (q_step && !tc_i) |=> (cnt_i == $past(cnt_i) + 1'b1));

endmodule

// File: tb/mul_seq_ctrl_bench.sv
module mul_seq_ctrl_bench;

    localparam logic [6:0] V_INNER = 7'b0010101;
    localparam logic [6:0] V_STEP  = 7'b0101110;
    localparam logic [6:0] V_DONE  = 7'b1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_v [3];
    logic [6:0] o_v [3];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    initial begin
        for (int k = 0; k < 3; k++) start_v[k] = 1'b0;
    end

    logic a0, b0, h0, l0, s0, c0, d0;
    logic a1, b1, h1, l1, s1, c1, d1;
    logic a2, b2, h2, l2, s2, c2, d2;

    mul_seq_ctrl u_mul_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_v[0]),
        .shift_a(a0), .shift_b(b0), .shift_hi(h0), .shift_lo(l0),
        .sel_sum(s0), .dp_clr(c0), .done(d0));

    mul_seq_ctrl #(.N(4)) u_mul_seq_ctrl_n4 (
        .clk(clk), .rst_n(rst_n), .start(start_v[1]),
        .shift_a(a1), .shift_b(b1), .shift_hi(h1), .shift_lo(l1),
        .sel_sum(s1), .dp_clr(c1), .done(d1));

    mul_seq_ctrl #(.N(5)) u_mul_seq_ctrl_n5 (
        .clk(clk), .rst_n(rst_n), .start(start_v[2]),
        .shift_a(a2), .shift_b(b2), .shift_hi(h2), .shift_lo(l2),
        .sel_sum(s2), .dp_clr(c2), .done(d2));

    assign o_v[0] = {d0, c0, s0, l0, h0, b0, a0};
    assign o_v[1] = {d1, c1, s1, l1, h1, b1, a1};
    assign o_v[2] = {d2, c2, s2, l2, h2, b2, a2};

    task automatic check(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // R2/R3/R4/R5/R6 (and R7 when poke is set): one full product on instance idx.
    task automatic run_product(input int idx, input int n, input bit poke);
        int total = n * (n + 1);
        int err_in = 0, err_st = 0, err_idle = 0;
        int na = 0, nb = 0, nd = 0, done_at = -1;
        logic [6:0] v, e;
        @(negedge clk) start_v[idx] = 1'b1;
        @(negedge clk) start_v[idx] = 1'b0;
        for (int c = 1; c <= total + 3; c++) begin
            if (c > 1) @(negedge clk);
            v = o_v[idx];
            if (c == 1) check("R2 first accumulate", v == V_INNER, v, V_INNER);
            if (c <= total) begin
                if (c % (n + 1) == 0) e = V_STEP | ((c == total) ? V_DONE : 7'b0);
                else                  e = V_INNER;
            end else begin
                e = 7'b0;
            end
            if (v !== e) begin
                if (c > total)                err_idle++;
                else if (c % (n + 1) == 0)    err_st++;
                else                          err_in++;
            end
            if (v[0]) na++;
            if (v[1]) nb++;
            if (v[6]) begin nd++; done_at = c; end
            start_v[idx] = poke && (c == 2 || c == n + 1 || c == n + 3);
        end
        start_v[idx] = 1'b0;
        check(poke ? "R7 start ignored, accumulate cycles" : "R3 accumulate cycles", err_in == 0, err_in, 0);
        check(poke ? "R7 start ignored, outer steps" : "R4 outer steps", err_st == 0, err_st, 0);
        check("R5 shift_a count", na == n * n, na, n * n);
        check("R5 shift_b count", nb == n, nb, n);
        check("R6 done pulse count", nd == 1, nd, 1);
        check("R6 done cycle", done_at == total, done_at, total);
        check("R6 idle after done", err_idle == 0, err_idle, 0);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) check("R1 outputs in reset", o_v[k] == 7'b0, o_v[k], 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 3; k++) check("R2 idle without start", o_v[k] == 7'b0, o_v[k], 0);
    endtask

    task automatic t_reset_mid_run();
        @(negedge clk) start_v[0] = 1'b1;
        @(negedge clk) start_v[0] = 1'b0;
        repeat (13) @(negedge clk);
        #1 rst_n = 1'b0;
        #1 check("R1 async reset mid-run", o_v[0] == 7'b0, o_v[0], 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", o_v[0] == 7'b0, o_v[0], 0);
        run_product(0, 8, 1'b0);
    endtask

    initial begin
        t_reset_state();
        run_product(1, 4, 1'b0);
        run_product(2, 5, 1'b0);
        run_product(0, 8, 1'b0);
        // R8: back-to-back runs start from cleared counters.
        run_product(1, 4, 1'b0);
        run_product(0, 8, 1'b0);
        run_product(1, 4, 1'b1);
        run_product(2, 5, 1'b1);
        t_reset_mid_run();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #400000;
        check("watchdog expired", 1'b0, 0, 1);
        finish_run();
    end

endmodule